// File: doc/BRIEF.md
# Prioritized Conversion Command Queue Arbiter

This block decides which of six command queues may send its next command word to one shared converter. Queues 1 to 5 each buffer a short FIFO of commands. A queue starts handing out its buffered batch once it is armed. Each queue is armed by either a one-cycle software strobe or a rising edge on a hardware trigger line, chosen per queue. When the converter signals ready, the lowest-numbered armed queue that still holds commands wins. Its head command is presented with a one-cycle start strobe.

Queue 0 is an express lane. It holds a single command register, not a FIFO, and takes no part in normal arbitration. Its trigger aborts whatever conversion is running and launches its own command after a fixed delay, whether or not the converter is ready. Normal grants are held off while this happens.

Two kinds of fault leave sticky per-queue flags, and each flag is cleared by writing 1. One is a push into a full FIFO, which is discarded. The other is a re-trigger that arrives while a batch is half sent. The coherency flags are also ORed into an interrupt line.

Top module: `cmd_queue_arbiter`

## Requirements
- R1: Among armed, non-empty queues 1..5, the one with the lowest index is granted first. Index 1 is highest and index 5 is lowest.
- R2: Each of queues 1..5 buffers up to 4 commands (push_qid selects the queue) and issues them in the order they were pushed.
- R3: A push into a full queue is discarded, and bit q of ovf_flags is set from the next cycle.
- R4: trig_sel bit q = 1 arms queue q on a rising edge of hw_trig[q], and sw_trig[q] has no effect. trig_sel bit q = 0 arms queue q on a high sw_trig[q] sample, and hw_trig[q] has no effect.
- R5: A normal grant happens only on a clock edge where conv_ready is high. Each grant issues one command, with start_o high for one cycle together with cmd_o and qid_o.
- R6: A queue-0 trigger sampled at edge k does three things. It raises abort_o for the cycle after edge k if conv_ready was low at edge k. It raises start_o with qid_o = 0 for the cycle after edge k+1, regardless of conv_ready. No normal grant is made at edges k and k+1.
- R7: Queue 0 holds one command. A later push to queue 0 overwrites it, and the express start sends the latest value.
- R8: A trigger is a coherency violation if it arrives at a queue that is armed, has sent at least one command and still holds commands. It sets bit q of coh_flags and drives coh_irq high. The queue goes on sending its remaining batch.
- R9: Writing 1 to flag_clr bit q clears coh_flags[q] and ovf_flags[q] on the next edge. If a new violation occurs in the same cycle, the set wins.
- R10: During and right after reset, start_o, abort_o, cmd_o, qid_o, all flags and coh_irq are zero, and every queue is empty and unarmed.
- R11: An armed queue disarms once its FIFO is empty. Commands pushed later are not issued until the queue is triggered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_en | input | 1 | Write a command into queue push_qid |
| push_qid | input | QID_W | Target queue of the write |
| push_cmd | input | CMD_W | Command word to write |
| trig_sel | input | NUM_Q | Per-queue trigger source, 1 = hardware edge, 0 = software strobe |
| sw_trig | input | NUM_Q | Software trigger strobes |
| hw_trig | input | NUM_Q | Hardware trigger lines (rising edge used) |
| conv_ready | input | 1 | Converter can accept a new command |
| flag_clr | input | NUM_Q | Write-1-to-clear for coherency and overflow flags |
| start_o | output | 1 | One-cycle start strobe for cmd_o |
| abort_o | output | 1 | One-cycle abort of the running conversion |
| cmd_o | output | CMD_W | Command being started |
| qid_o | output | QID_W | Queue that supplied cmd_o |
| coh_flags | output | NUM_Q | Sticky coherency-violation flags |
| ovf_flags | output | NUM_Q | Sticky dropped-push flags |
| coh_irq | output | 1 | Interrupt, high while any coherency flag is set |

## Verification
A queue-0 express trigger and a normal grant can both become due on the same clock edge. The bench provokes this by arming queue 2 while conv_ready is low, then raising conv_ready and a queue-0 trigger in the same cycle. The bench expects no abort and no start in the first cycle, then a start from queue 0, then the queue-2 command one cycle after that. A second pair can also coincide: a re-trigger that lands between two grants of one batch. The bench expects the flag to rise while the rest of the batch still drains in order.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // per-queue trigger source encoding (one trig_sel bit per queue)
  typedef enum logic {
    SRC_SW = 1'b0,
    SRC_HW = 1'b1
  } trig_src_e;

endpackage

// File: rtl/trig_detect.sv
module trig_detect
  import arb_pkg::*;
#(
  parameter int unsigned NUM_Q = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_Q-1:0] sel,
  input  logic [NUM_Q-1:0] sw,
  input  logic [NUM_Q-1:0] hw,
  output logic [NUM_Q-1:0] evt
);

  logic [NUM_Q-1:0] hw_prev_q;

  always_comb begin
    for (int i = 0; i < NUM_Q; i++) begin
      if (trig_src_e'(sel[i]) == SRC_HW) evt[i] = hw[i] & ~hw_prev_q[i];
      else                                evt[i] = sw[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hw_prev_q <= '0;
    else        hw_prev_q <= hw;
  end

endmodule

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);

  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q, wr_n, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign rdata = mem[rd_q];

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (push) wr_n = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
    if (pop)  rd_n = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
    unique case ({push, pop})
      2'b10:   cnt_n = cnt_q + CW'(1);
      2'b01:   cnt_n = cnt_q - CW'(1);
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

  // the parent must never push into a full buffer (drops are handled above)
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // a grant may only pop a buffer that holds a command
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);

  // scan from the lowest-priority end so the lowest index overrides
  always_comb begin
    gnt = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        any    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cmd_queue_arbiter.sv
module cmd_queue_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned NUM_Q = 6,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CMD_W = 16,
  parameter int unsigned QID_W = $clog2(NUM_Q)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [QID_W-1:0] push_qid,
  input  logic [CMD_W-1:0] push_cmd,
  input  logic [NUM_Q-1:0] trig_sel,
  input  logic [NUM_Q-1:0] sw_trig,
  input  logic [NUM_Q-1:0] hw_trig,
  input  logic             conv_ready,
  input  logic [NUM_Q-1:0] flag_clr,
  output logic             start_o,
  output logic             abort_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [QID_W-1:0] qid_o,
  output logic [NUM_Q-1:0] coh_flags,
  output logic [NUM_Q-1:0] ovf_flags,
  output logic             coh_irq
);

  logic [NUM_Q-1:0] evt, push_hit, q_empty, q_full, elig, gnt;
  logic [CMD_W-1:0] q_head [NUM_Q];
  logic             any_req, blocked, grant_ok;
  logic [CMD_W-1:0] head_sel;
  logic [QID_W-1:0] head_id;

  logic [NUM_Q-1:0] armed_q, armed_n, sent_q, sent_n;
  logic [NUM_Q-1:0] coh_q, coh_n, ovf_q, ovf_n, coh_set, ovf_set;
  logic [CMD_W-1:0] q0_cmd_q, q0_cmd_n, cmd_q, cmd_n;
  logic [QID_W-1:0] qid_q, qid_n;
  logic             q0_pend_q, q0_pend_n, start_q, start_n, abort_q, abort_n;

  trig_detect #(.NUM_Q(NUM_Q)) u_trig (
    .clk(clk), .rst_n(rst_n), .sel(trig_sel), .sw(sw_trig), .hw(hw_trig), .evt(evt)
  );

  always_comb begin
    for (int i = 0; i < NUM_Q; i++) push_hit[i] = push_en && (push_qid == QID_W'(i));
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    if (g == 0) begin : g_express
      assign q_empty[g] = 1'b1;
      assign q_full[g]  = 1'b0;
      assign q_head[g]  = '0;
    end else begin : g_fifo
      logic push_g, pop_g;
      assign push_g = push_hit[g] & ~q_full[g];
      assign pop_g  = grant_ok & gnt[g];
      cmdq_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_g), .pop(pop_g), .wdata(push_cmd),
        .rdata(q_head[g]), .empty(q_empty[g]), .full(q_full[g])
      );
    end
  end

  // arbitration among buffered queues; held off around an express start
  assign elig     = armed_q & ~q_empty;
  assign blocked  = evt[0] | q0_pend_q;
  assign grant_ok = conv_ready & ~blocked;

  prio_pick #(.N(NUM_Q)) u_pick (.req(elig), .gnt(gnt), .any(any_req));

  always_comb begin
    head_sel = '0;
    head_id  = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      if (gnt[i]) begin
        head_sel = head_sel | q_head[i];
        head_id  = QID_W'(i);
      end
    end
  end

  // next state: arming, batch progress, flags, express pipeline, outputs
  always_comb begin
    armed_n = armed_q;
    sent_n  = sent_q;
    for (int i = 1; i < NUM_Q; i++) begin
      if (grant_ok && gnt[i]) sent_n[i] = 1'b1;
      if (armed_q[i] && q_empty[i]) begin
        armed_n[i] = 1'b0;
        sent_n[i]  = 1'b0;
      end
      if (evt[i] && !(armed_q[i] && !q_empty[i])) begin
        armed_n[i] = 1'b1;
        sent_n[i]  = 1'b0;
      end
    end
    armed_n[0] = 1'b0;
    sent_n[0]  = 1'b0;

    coh_set = evt & armed_q & sent_q & ~q_empty;
    ovf_set = push_hit & q_full;
    coh_n   = (coh_q & ~flag_clr) | coh_set;
    ovf_n   = (ovf_q & ~flag_clr) | ovf_set;

    q0_cmd_n  = push_hit[0] ? push_cmd : q0_cmd_q;
    q0_pend_n = evt[0];

    start_n = q0_pend_q | (grant_ok & any_req);
    abort_n = evt[0] & ~conv_ready;
    cmd_n   = q0_pend_q ? q0_cmd_q : head_sel;
    qid_n   = q0_pend_q ? '0 : head_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= '0;
      sent_q    <= '0;
      coh_q     <= '0;
      ovf_q     <= '0;
      q0_cmd_q  <= '0;
      q0_pend_q <= 1'b0;
      start_q   <= 1'b0;
      abort_q   <= 1'b0;
      cmd_q     <= '0;
      qid_q     <= '0;
    end else begin
      armed_q   <= armed_n;
      sent_q    <= sent_n;
      coh_q     <= coh_n;
      ovf_q     <= ovf_n;
      q0_cmd_q  <= q0_cmd_n;
      q0_pend_q <= q0_pend_n;
      start_q   <= start_n;
      abort_q   <= abort_n;
      if (start_n) begin
        cmd_q <= cmd_n;
        qid_q <= qid_n;
      end
    end
  end

  assign start_o   = start_q;
  assign abort_o   = abort_q;
  assign cmd_o     = cmd_q;
  assign qid_o     = qid_q;
  assign coh_flags = coh_q;
  assign ovf_flags = ovf_q;
  assign coh_irq   = |coh_q;

  // a start from a buffered queue implies the converter was ready
  assert_ready_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && qid_o != '0) |-> $past(conv_ready));

  // an abort is always followed by the express start one cycle later
  assert_abort_then_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> (start_o && qid_o == '0));

  // an express trigger leads to the queue-0 start after the next edge
  assert_express_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |=> ##1 (start_o && qid_o == '0));

  // the interrupt only drops after a clear request
  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(coh_irq) |-> $past(|flag_clr));

  // a queue's coherency flag only rises on a trigger to that queue
  assert_coh_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coh_irq) |-> $past(|(evt & armed_q)));

endmodule

// File: tb/sim_cmd_queue_arbiter.sv
`timescale 1ns/1ps
module sim_cmd_queue_arbiter;

  localparam int NQ = 6;
  localparam int CW = 16;
  localparam int QW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          push_en;
  logic [QW-1:0] push_qid;
  logic [CW-1:0] push_cmd;
  logic [NQ-1:0] trig_sel, sw_trig, hw_trig, flag_clr;
  logic          conv_ready;
  logic          start_o, abort_o, coh_irq;
  logic [CW-1:0] cmd_o;
  logic [QW-1:0] qid_o;
  logic [NQ-1:0] coh_flags, ovf_flags;

  int n_chk = 0;
  int n_err = 0;
  int got_n;
  logic [CW-1:0] got_cmd [8];
  logic [QW-1:0] got_q [8];

  always #4 clk = ~clk;

  cmd_queue_arbiter #(.NUM_Q(NQ), .DEPTH(4), .CMD_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_qid(push_qid),
    .push_cmd(push_cmd), .trig_sel(trig_sel), .sw_trig(sw_trig), .hw_trig(hw_trig),
    .conv_ready(conv_ready), .flag_clr(flag_clr), .start_o(start_o), .abort_o(abort_o),
    .cmd_o(cmd_o), .qid_o(qid_o), .coh_flags(coh_flags), .ovf_flags(ovf_flags),
    .coh_irq(coh_irq)
  );

  // vector: {queue mask (bit q = queue q, bit 0 unused), expected first queue}
  localparam logic [8:0] VEC [6] = '{
    {6'b111110, 3'd1}, {6'b110000, 3'd4}, {6'b101000, 3'd3},
    {6'b100000, 3'd5}, {6'b010100, 3'd2}, {6'b000010, 3'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input int q, input logic [CW-1:0] c);
    @(negedge clk);
    push_en = 1'b1; push_qid = QW'(q); push_cmd = c;
    @(negedge clk);
    push_en = 1'b0;
  endtask

  // records the starts seen over n cycles; clears trigger inputs after the first edge
  task automatic collect(input int n);
    got_n = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      sw_trig = '0;
      hw_trig = '0;
      if (start_o && got_n < 8) begin
        got_cmd[got_n] = cmd_o;
        got_q[got_n]   = qid_o;
        got_n++;
      end
    end
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; push_en = 1'b0; push_qid = '0; push_cmd = '0;
    trig_sel = '0; sw_trig = '0; hw_trig = '0; flag_clr = '0; conv_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 start in reset", start_o, 0);
    chk("R10 flags in reset", {coh_flags, ovf_flags, coh_irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 outputs after reset", {start_o, abort_o, cmd_o, qid_o}, 0);

    // R1 table: priority order among buffered queues
    for (int v = 0; v < 6; v++) begin
      logic [5:0] m;
      int exp_n;
      m = VEC[v][8:3];
      exp_n = 0;
      for (int q = 1; q < NQ; q++) begin
        if (m[q]) begin
          push(q, {8'(q), 8'(v)});
          exp_n++;
        end
      end
      @(negedge clk);
      sw_trig = m;
      collect(8);
      chk("R1 grant count", got_n, exp_n);
      chk("R1 first queue", got_q[0], VEC[v][2:0]);
      for (int k = 1; k < got_n; k++) chk("R1 ascending order", got_q[k] > got_q[k-1], 1);
      for (int k = 0; k < got_n; k++) chk("R1 command matches queue", got_cmd[k], {8'(got_q[k]), 8'(v)});
    end

    // R2/R3: depth, order, dropped push, sticky flag
    for (int k = 0; k < 5; k++) push(3, 16'hA1 + 16'(k));
    chk("R3 overflow flag", ovf_flags, 6'b001000);
    @(negedge clk);
    sw_trig = 6'b001000;
    collect(8);
    chk("R2 four issued", got_n, 4);
    for (int k = 0; k < 4; k++) chk("R2 fifo order", got_cmd[k], 16'hA1 + 16'(k));
    chk("R3 flag sticky", ovf_flags, 6'b001000);
    flag_clr = 6'b001000;
    @(negedge clk);
    flag_clr = '0;
    chk("R9 overflow cleared", ovf_flags, 0);

    // R5: ready gating, one-cycle start
    conv_ready = 1'b0;
    push(2, 16'hB1);
    @(negedge clk);
    sw_trig = 6'b000100;
    collect(4);
    chk("R5 no grant while not ready", got_n, 0);
    conv_ready = 1'b1;
    @(negedge clk);
    chk("R5 start on ready", {start_o, qid_o, cmd_o}, {1'b1, 3'd2, 16'hB1});
    @(negedge clk);
    chk("R5 start is one cycle", start_o, 0);

    // R11: drained queue is disarmed
    push(2, 16'hB2);
    collect(4);
    chk("R11 no issue without trigger", got_n, 0);
    @(negedge clk);
    sw_trig = 6'b000100;
    collect(4);
    chk("R11 issue after retrigger", {got_n[3:0], got_cmd[0]}, {4'd1, 16'hB2});

    // R4: trigger source selection
    trig_sel = 6'b010000;
    push(4, 16'hC1);
    @(negedge clk);
    sw_trig = 6'b010000;
    collect(4);
    chk("R4 software strobe ignored when hw selected", got_n, 0);
    @(negedge clk);
    hw_trig = 6'b010000;
    collect(4);
    chk("R4 hw edge arms", {got_n[3:0], got_q[0]}, {4'd1, 3'd4});
    trig_sel = '0;
    push(5, 16'hD1);
    @(negedge clk);
    hw_trig = 6'b100000;
    collect(4);
    chk("R4 hw edge ignored when sw selected", got_n, 0);
    @(negedge clk);
    sw_trig = 6'b100000;
    collect(4);
    chk("R4 sw strobe arms", {got_n[3:0], got_cmd[0]}, {4'd1, 16'hD1});

    // R8: re-trigger mid-batch
    conv_ready = 1'b0;
    push(1, 16'hE1); push(1, 16'hE2); push(1, 16'hE3);
    @(negedge clk);
    sw_trig = 6'b000010;
    @(negedge clk);
    sw_trig = '0;
    conv_ready = 1'b1;
    @(negedge clk);
    conv_ready = 1'b0;
    chk("R8 first of batch", {start_o, cmd_o}, {1'b1, 16'hE1});
    sw_trig = 6'b000010;
    @(negedge clk);
    sw_trig = '0;
    chk("R8 coherency flag", coh_flags, 6'b000010);
    chk("R8 interrupt", coh_irq, 1);
    conv_ready = 1'b1;
    collect(6);
    chk("R8 batch continues", {got_n[3:0], got_cmd[0], got_cmd[1]}, {4'd2, 16'hE2, 16'hE3});
    flag_clr = 6'b000010;
    @(negedge clk);
    flag_clr = '0;
    chk("R9 interrupt cleared", {coh_irq, coh_flags}, 0);

    // R6/R7: express path while converter busy
    conv_ready = 1'b0;
    push(0, 16'h51);
    push(0, 16'h52);
    push(2, 16'h61);
    @(negedge clk);
    sw_trig = 6'b000100;
    collect(2);
    sw_trig = 6'b000001;
    @(negedge clk);
    sw_trig = '0;
    chk("R6 abort after trigger", {abort_o, start_o}, 2'b10);
    @(negedge clk);
    chk("R6 express start", {start_o, qid_o, abort_o}, {1'b1, 3'd0, 1'b0});
    chk("R7 latest queue-0 command", cmd_o, 16'h52);
    @(negedge clk);
    chk("R5 busy converter blocks queue 2", start_o, 0);

    // R6: express trigger and normal grant due on the same edge
    conv_ready = 1'b1;
    sw_trig = 6'b000001;
    @(negedge clk);
    sw_trig = '0;
    chk("R6 no abort and no grant at trigger edge", {abort_o, start_o}, 2'b00);
    @(negedge clk);
    chk("R6 express wins", {start_o, qid_o}, {1'b1, 3'd0});
    @(negedge clk);
    chk("R6 queue 2 follows", {start_o, qid_o, cmd_o}, {1'b1, 3'd2, 16'h61});

    repeat (3) @(negedge clk);
    report();
  end

endmodule